// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Bank

This block watches a bank of general-purpose input pins and turns selected transitions on them into a single interrupt request. Each pin passes through a reset-cleared synchronizer chain. A small per-pin tracker then follows the synchronized level and reports a rising or a falling transition. The pin's 2-bit trigger code selects which of those transitions count. Level-sensitive triggering is not offered.

Qualified transitions set sticky bits in a status register. Software clears a status bit by writing a one to it. A mask register suppresses selected bits from the interrupt line. Software never writes the mask directly. It sets mask bits through one address and clears them through another, so each write touches only the bits that are written as one. The interrupt line is high whenever some status bit is set and its mask bit is clear. Status bits are still captured while masked, so unmasking a pending pin raises the line at once. Software may clear a bit before it services the pin, and a transition that arrives after the clear is latched again.

The tracker of each pin has two states: `TRK_LOW` and `TRK_HIGH`. There are two transitions. RISE goes from `TRK_LOW` to `TRK_HIGH` when the synchronized level is 1. FALL goes from `TRK_HIGH` to `TRK_LOW` when the synchronized level is 0. A transition produces an event in the same cycle it is taken, provided the pin's trigger code enables it.

Top module: `edgeirq_bank`

## Requirements
- R1: After reset the status reads 0, the mask reads all ones, every trigger word reads 0 and `irq_out` is 0.
- R2: Trigger code 1 latches the pin's status bit on a 0-to-1 pin change only.
- R3: Trigger code 2 latches the pin's status bit on a 1-to-0 pin change only.
- R4: Trigger code 3 latches the pin's status bit on either pin change.
- R5: Trigger code 0 never latches the pin's status bit.
- R6: Address 0 reads the status register. Writing 1 to a bit clears that bit. Writing 0 leaves the bit unchanged.
- R7: A write to address 1 sets every mask bit written as 1. A write to address 2 clears every mask bit written as 1. Zero bits leave the mask unchanged. Both addresses read back the mask.
- R8: `irq_out` is the OR over all pins of (status AND NOT mask). Status bits latch while masked. Clearing the mask bit of a pending pin raises `irq_out` in the cycle after that write.
- R9: A transition that qualifies in the same cycle as a clear write to that bit leaves the bit set.
- R10: A pin change applied just after a clock edge sets its status bit at the third following rising edge, and not earlier.
- R11: Trigger words sit at addresses 4 and up. Pin p uses bits [2*(p mod 16)+1 : 2*(p mod 16)] of word 4 + p/16. The words are read/write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | NPINS | Asynchronous pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Bank interrupt request |

## Verification
A pin change moves through two synchronizer flops and then the status register. Its status bit is therefore due at the third rising edge after the change. The bench reads status one half period after the second edge, where the bit must still be clear, and again after the third edge, where it must be set. Register writes take effect at the single rising edge during which the strobe is high. Reads are combinational, so every register and `irq_out` result is sampled at the falling edge that follows the write. The same-cycle case for R9 is built by raising the clear strobe exactly over the third edge after the pin change.

// File: rtl/edgeirq_pkg.sv
package edgeirq_pkg;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_BOTH = 2'd3
    } trig_e;

    typedef enum logic {
        TRK_LOW  = 1'b0,
        TRK_HIGH = 1'b1
    } trk_e;

    localparam int unsigned REG_STATUS    = 0;
    localparam int unsigned REG_MASK_SET  = 1;
    localparam int unsigned REG_MASK_CLR  = 2;
    localparam int unsigned REG_TRIG_BASE = 4;

endpackage

// File: rtl/edgeirq_sync.sv
module edgeirq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/edgeirq_tracker.sv
module edgeirq_tracker
    import edgeirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  level,
    input  trig_e trig,
    output logic  evt
);

    trk_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_LOW;
        else        state_q <= state_d;
    end

    // Next state: RISE (LOW->HIGH) and FALL (HIGH->LOW)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_LOW:  if (level)  state_d = TRK_HIGH;
            TRK_HIGH: if (!level) state_d = TRK_LOW;
        endcase
    end

    // Outputs: event on a taken transition that the trigger code enables
    always_comb begin
        evt = 1'b0;
        unique case (state_q)
            TRK_LOW:  evt = level  && (trig == TRIG_RISE || trig == TRIG_BOTH);
            TRK_HIGH: evt = !level && (trig == TRIG_FALL || trig == TRIG_BOTH);
        endcase
    end

endmodule

// File: rtl/edgeirq_status.sv
module edgeirq_status #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] evt,
    input  logic             wr_clear,
    input  logic             wr_mask_set,
    input  logic             wr_mask_clr,
    input  logic [NPINS-1:0] wbits,
    output logic [NPINS-1:0] status_q,
    output logic [NPINS-1:0] mask_q,
    output logic             irq
);

    logic [NPINS-1:0] clear_bits;

    assign clear_bits = wr_clear ? wbits : '0;

    // A new event wins over a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clear_bits) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           mask_q <= '1;
        else if (wr_mask_set) mask_q <= mask_q | wbits;
        else if (wr_mask_clr) mask_q <= mask_q & ~wbits;
    end

    assign irq = |(status_q & ~mask_q);

endmodule

// File: rtl/edgeirq_bank.sv
module edgeirq_bank
    import edgeirq_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pins_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);

    localparam int PINS_PER_WORD = DATA_W / 2;
    localparam int TRIG_WORDS    = (NPINS + PINS_PER_WORD - 1) / PINS_PER_WORD;
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
    localparam logic [ADDR_W-1:0] A_MSET   = ADDR_W'(REG_MASK_SET);
    localparam logic [ADDR_W-1:0] A_MCLR   = ADDR_W'(REG_MASK_CLR);

    logic [NPINS-1:0]   level_sync;
    logic [NPINS-1:0]   evt_vec;
    logic [NPINS-1:0]   status_vec;
    logic [NPINS-1:0]   mask_vec;
    logic [2*NPINS-1:0] trig_all;
    logic               hit_status, hit_mset, hit_mclr;

    assign hit_status = reg_we && (reg_addr == A_STATUS);
    assign hit_mset   = reg_we && (reg_addr == A_MSET);
    assign hit_mclr   = reg_we && (reg_addr == A_MCLR);

    edgeirq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_in),
        .q     (level_sync)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam int WORD = p / PINS_PER_WORD;
        localparam int LSB  = 2 * (p % PINS_PER_WORD);
        localparam logic [ADDR_W-1:0] A_WORD = ADDR_W'(REG_TRIG_BASE + WORD);

        logic [1:0] trig_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             trig_r <= '0;
            else if (reg_we && reg_addr == A_WORD)  trig_r <= reg_wdata[LSB +: 2];
        end

        assign trig_all[2*p +: 2] = trig_r;

        edgeirq_tracker u_trk (
            .clk   (clk),
            .rst_n (rst_n),
            .level (level_sync[p]),
            .trig  (trig_e'(trig_r)),
            .evt   (evt_vec[p])
        );
    end

    edgeirq_status #(.NPINS(NPINS)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt_vec),
        .wr_clear    (hit_status),
        .wr_mask_set (hit_mset),
        .wr_mask_clr (hit_mclr),
        .wbits       (reg_wdata[NPINS-1:0]),
        .status_q    (status_vec),
        .mask_q      (mask_vec),
        .irq         (irq_out)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STATUS) begin
            reg_rdata[NPINS-1:0] = status_vec;
        end else if (reg_addr == A_MSET || reg_addr == A_MCLR) begin
            reg_rdata[NPINS-1:0] = mask_vec;
        end else begin
            for (int w = 0; w < TRIG_WORDS; w++) begin
                if (reg_addr == ADDR_W'(REG_TRIG_BASE + w)) begin
                    for (int i = 0; i < PINS_PER_WORD; i++) begin
                        if (w * PINS_PER_WORD + i < NPINS)
                            reg_rdata[2*i +: 2] = trig_all[2*(w*PINS_PER_WORD + i) +: 2];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/edgeirq_checker.sv
module edgeirq_checker
    import edgeirq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [NPINS-1:0]  evt,
    input logic [NPINS-1:0]  status_q,
    input logic [NPINS-1:0]  mask_q,
    input logic              irq_out
);

    localparam logic [ADDR_W-1:0] C_STATUS = ADDR_W'(REG_STATUS);
    localparam logic [ADDR_W-1:0] C_MSET   = ADDR_W'(REG_MASK_SET);
    localparam logic [ADDR_W-1:0] C_MCLR   = ADDR_W'(REG_MASK_CLR);

    logic [NPINS-1:0] wbits;
    assign wbits = reg_wdata[NPINS-1:0];

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == '1 && status_q == '0 && !irq_out));

    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == C_STATUS) |=> ((status_q & $past(wbits & ~evt)) == '0));

    assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == C_MSET) |=> ((mask_q & $past(wbits)) == $past(wbits)));

    assert_mask_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == C_MCLR) |=> ((mask_q & $past(wbits)) == '0));

    assert_unmask_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == C_MCLR && |(status_q & wbits)) |=> irq_out);

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq_out);

    assert_edge_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((status_q & $past(evt)) == $past(evt)));

endmodule

bind edgeirq_bank edgeirq_checker #(
    .NPINS  (NPINS),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .evt       (evt_vec),
    .status_q  (status_vec),
    .mask_q    (mask_vec),
    .irq_out   (irq_out)
);

// File: tb/sim_edgeirq_bank.sv
`timescale 1ns/1ps
module sim_edgeirq_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    logic [1:0] tb_trig [32];

    always #4 clk = ~clk;

    edgeirq_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_in   (pins),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] trig_word(input int w);
        logic [31:0] r;
        for (int i = 0; i < 16; i++) r[2*i +: 2] = tb_trig[w*16 + i];
        return r;
    endfunction

    task automatic set_trig(input int p, input logic [1:0] c);
        tb_trig[p] = c;
        wr(3'(4 + p/16), trig_word(p/16));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp;
        string tag;
        for (int i = 0; i < 32; i++) tb_trig[i] = 2'd0;

        cycles(3);
        rst_n = 1'b1;
        cycles(1);

        // R1: reset state
        rd(3'd0, v); check(v, 32'h0, "R1 status");
        rd(3'd1, v); check(v, 32'hFFFF_FFFF, "R1 mask");
        rd(3'd4, v); check(v, 32'h0, "R1 trig word 4");
        rd(3'd5, v); check(v, 32'h0, "R1 trig word 5");
        check(32'(irq_out), 32'h0, "R1 irq");

        // R11: trigger word layout readback
        wr(3'd4, 32'h0000_001B);
        rd(3'd4, v); check(v, 32'h0000_001B, "R11 word 4 readback");
        rd(3'd5, v); check(v, 32'h0, "R11 word 5 untouched");
        wr(3'd5, 32'hC000_0002);
        rd(3'd5, v); check(v, 32'hC000_0002, "R11 word 5 readback");
        wr(3'd4, 32'h0); wr(3'd5, 32'h0);

        // Sweep every pin and every trigger code, both directions
        for (int p = 0; p < 32; p++) begin
            for (int c = 0; c < 4; c++) begin
                tag = (c == 0) ? "R5" : (c == 1) ? "R2" : (c == 2) ? "R3" : "R4";
                set_trig(p, 2'(c));
                pins[p] = 1'b1;
                cycles(2);
                rd(3'd0, v); check(v, 32'h0, "R10 not before third edge (rise)");
                cycles(1);
                exp = (c == 1 || c == 3) ? (32'h1 << p) : 32'h0;
                rd(3'd0, v); check(v, exp, {tag, " rising"});
                check(32'(irq_out), 32'h0, "R8 masked stays quiet");
                wr(3'd0, 32'hFFFF_FFFF);
                pins[p] = 1'b0;
                cycles(2);
                rd(3'd0, v); check(v, 32'h0, "R10 not before third edge (fall)");
                cycles(1);
                exp = (c == 2 || c == 3) ? (32'h1 << p) : 32'h0;
                rd(3'd0, v); check(v, exp, {tag, " falling"});
                wr(3'd0, 32'hFFFF_FFFF);
            end
            set_trig(p, 2'd0);
        end

        // R7: mask set / clear
        wr(3'd2, 32'h0000_000F);
        rd(3'd1, v); check(v, 32'hFFFF_FFF0, "R7 mask clear");
        wr(3'd1, 32'h0000_0001);
        rd(3'd2, v); check(v, 32'hFFFF_FFF1, "R7 mask set");
        wr(3'd1, 32'h0); wr(3'd2, 32'h0);
        rd(3'd1, v); check(v, 32'hFFFF_FFF1, "R7 zero writes ignored");
        wr(3'd1, 32'hFFFF_FFFF);

        // R8: latch while masked, unmask raises irq
        set_trig(5, 2'd1);
        pins[5] = 1'b1;
        cycles(3);
        rd(3'd0, v); check(v, 32'h0000_0020, "R8 latched while masked");
        check(32'(irq_out), 32'h0, "R8 masked no irq");
        wr(3'd2, 32'h0000_0020);
        check(32'(irq_out), 32'h1, "R8 unmask raises irq");
        wr(3'd1, 32'h0000_0020);
        check(32'(irq_out), 32'h0, "R8 remask drops irq");
        wr(3'd2, 32'h0000_0020);
        check(32'(irq_out), 32'h1, "R8 unmask again");

        // R6: write-one-to-clear
        wr(3'd0, 32'h0);
        rd(3'd0, v); check(v, 32'h0000_0020, "R6 zero write keeps status");
        wr(3'd0, 32'hFFFF_FFDF);
        rd(3'd0, v); check(v, 32'h0000_0020, "R6 other bits no effect");
        wr(3'd0, 32'h0000_0020);
        rd(3'd0, v); check(v, 32'h0, "R6 one clears");
        check(32'(irq_out), 32'h0, "R6 irq drops after clear");

        // R9: edge coinciding with clear keeps bit set
        set_trig(5, 2'd3);
        pins[5] = 1'b0;
        cycles(3);
        rd(3'd0, v); check(v, 32'h0000_0020, "R9 bit pending");
        pins[5] = 1'b1;
        cycles(2);
        wr(3'd0, 32'h0000_0020);
        rd(3'd0, v); check(v, 32'h0000_0020, "R9 same-cycle edge wins");
        check(32'(irq_out), 32'h1, "R9 irq still high");
        wr(3'd0, 32'h0000_0020);
        rd(3'd0, v); check(v, 32'h0, "R9 plain clear");
        pins[5] = 1'b0;
        cycles(3);
        rd(3'd0, v); check(v, 32'h0000_0020, "R9 later edge latched again");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule